// File: doc/BRIEF.md
# Per-Pin GPIO Interrupt Detector

This block turns the synchronised levels of a 32-pin general-purpose I/O port into interrupt requests. Software sets up each pin through five configuration registers: enable, mask, trigger type, polarity and a both-transitions option. A pin can fire on its active level, on one chosen edge, or on every transition. Edge events are held in a pending bit until software clears them with a write-one acknowledge. The block shows the unmasked (raw) pending picture and the masked picture, and ORs the masked picture into a single interrupt line for the system interrupt controller.

All writable registers use the half-word write-mask convention of the port. Each 32-bit register is split into two 16-pin halves at consecutive word addresses. On a write, bits [31:16] of the data select which of the sixteen bits in [15:0] are changed. Reads are combinational from the address and return the selected half in [15:0], with zeros above. Register access is plain control traffic with no handshake. A write is taken on the clock edge where `reg_wen` is high.

Top module: `gpio_irq_detect`

## Requirements
- R1: After reset, every configuration register and every pending edge bit is 0, every readable address returns 0 while the pins are held low, and `irq` is 0.
- R2: A write to a register's low-half address (base) changes pins 15..0 and a write to base+4 changes pins 31..16. Within that half, bit i takes `reg_wdata[i]` only when `reg_wdata[16+i]` is 1, and keeps its value otherwise. A read of either address returns that half in bits [15:0] and zeros in [31:16]. The bases are: enable 0x10, mask 0x18, type 0x20, polarity 0x28, both-edge 0x30, masked status 0x50, raw status 0x58, end-of-interrupt 0x60.
- R3: For an enabled pin with type 0 and both-edge 0 (level mode), the raw bit is 1 in the same cycle that the pin equals its polarity bit (1 = active high, 0 = active low), and it is 0 otherwise.
- R4: For an enabled pin with type 1 (edge mode), polarity 1 latches a rising transition and polarity 0 latches a falling one. The raw bit reads 1 from the clock edge that samples the new level, and it stays 1 after the pin returns.
- R5: When a pin's both-edge bit is 1, the pin is edge-triggered on both rising and falling transitions, whatever its type and polarity bits.
- R6: Writing the end-of-interrupt address with a bit and its write-enable both 1 clears that pin's pending edge bit on that clock edge. The other bits are untouched, and reads of the end-of-interrupt addresses return 0.
- R7: End-of-interrupt has no effect on a level-mode pin: its raw bit still follows the pin.
- R8: If a new edge is sampled on the same clock edge as that pin's end-of-interrupt clear, the pending bit stays 1.
- R9: Masked status equals raw status with every masked pin (mask bit 1) forced to 0. A mask bit never changes raw status.
- R10: `irq` is 1 exactly when at least one masked status bit is 1.
- R11: A pin with enable 0 reads 0 in raw status, and its pending edge bit is cleared. A transition that arrives while it is disabled is not remembered when it is enabled again.
- R12: Writes to the status and raw status addresses change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_lvl | input | 32 | Synchronised pin levels |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | 8 | Byte address for reads and writes |
| reg_wdata | input | 32 | Write data: [31:16] bit enables, [15:0] values |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench aims at the acknowledge collision: an edge sampled on the same edge as its clear. A design that lets the clear win would silently drop that interrupt. It drives rising edges into falling-polarity pins with both-edge set and cleared, which exposes a design that ignores the both-edge bit or lets polarity gate it. It writes end-of-interrupt without write-enable bits and to level-mode pins, where a wrong decode would clear pending state or hide an asserted level. It toggles pins while they are disabled, where a design that keeps detecting would raise a stale interrupt on re-enable. Random traffic with sparse pin toggles then checks raw status, masked status and `irq` on every cycle against a bench model.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int unsigned ADDR_W = 8;
  localparam logic [ADDR_W-1:0] OFS_EN   = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_MASK = 8'h18;
  localparam logic [ADDR_W-1:0] OFS_TYPE = 8'h20;
  localparam logic [ADDR_W-1:0] OFS_POL  = 8'h28;
  localparam logic [ADDR_W-1:0] OFS_BOTH = 8'h30;
  localparam logic [ADDR_W-1:0] OFS_STAT = 8'h50;
  localparam logic [ADDR_W-1:0] OFS_RAW  = 8'h58;
  localparam logic [ADDR_W-1:0] OFS_EOI  = 8'h60;
  // upper half of every register sits one word above its base
  localparam logic [ADDR_W-1:0] HI_STEP  = 8'h04;
endpackage

// File: rtl/gpio_wm_reg.sv
module gpio_wm_reg
  import gpio_irq_pkg::*;
#(
  parameter int unsigned        HW   = 16,
  parameter logic [ADDR_W-1:0]  BASE = OFS_EN
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wen,
  input  logic [ADDR_W-1:0] addr,
  input  logic [2*HW-1:0]   wdata,
  output logic [2*HW-1:0]   q
);
  logic [HW-1:0] bit_we;
  logic [HW-1:0] bit_val;

  assign bit_we  = wdata[2*HW-1:HW];
  assign bit_val = wdata[HW-1:0];

  for (genvar h = 0; h < 2; h++) begin : g_half
    localparam logic [ADDR_W-1:0] HALF_ADDR = BASE + ADDR_W'(h * HI_STEP);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        q[h*HW +: HW] <= '0;
      else if (wen && addr == HALF_ADDR)
        q[h*HW +: HW] <= (q[h*HW +: HW] & ~bit_we) | (bit_val & bit_we);
    end
  end
endmodule

// File: rtl/gpio_pin_detect.sv
module gpio_pin_detect #(
  parameter int unsigned NP = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NP-1:0] pin,
  input  logic [NP-1:0] en,
  input  logic [NP-1:0] etype,
  input  logic [NP-1:0] pol,
  input  logic [NP-1:0] both,
  input  logic [NP-1:0] eoi_clr,
  output logic [NP-1:0] hit,
  output logic [NP-1:0] pend,
  output logic [NP-1:0] raw
);
  logic [NP-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= pin;
  end

  for (genvar p = 0; p < NP; p++) begin : g_pin
    logic edge_mode, rise, fall, ev;
    assign edge_mode = etype[p] | both[p];
    assign rise      = pin[p] & ~prev_q[p];
    assign fall      = ~pin[p] & prev_q[p];
    assign ev        = both[p] ? (rise | fall) : (pol[p] ? rise : fall);
    assign hit[p]    = en[p] & edge_mode & ev;
    assign raw[p]    = en[p] & (edge_mode ? pend[p] : ~(pin[p] ^ pol[p]));

    // a fresh edge overrides an acknowledge landing on the same edge
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        pend[p] <= 1'b0;
      else if (en[p] && edge_mode)
        pend[p] <= (pend[p] & ~eoi_clr[p]) | hit[p];
      else
        pend[p] <= 1'b0;
    end
  end
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NPINS = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPINS-1:0]  pin_lvl,
  input  logic              reg_wen,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [NPINS-1:0]  reg_wdata,
  output logic [NPINS-1:0]  reg_rdata,
  output logic              irq
);
  localparam int unsigned HW = NPINS / 2;

  logic [NPINS-1:0] cfg_en, cfg_mask, cfg_type, cfg_pol, cfg_both;
  logic [NPINS-1:0] eoi_clr, hit, pend, raw, stat;
  logic [NPINS-1:0] rd_sel;

  gpio_wm_reg #(.HW(HW), .BASE(OFS_EN)) u_en (
    .clk(clk), .rst_n(rst_n), .wen(reg_wen), .addr(reg_addr), .wdata(reg_wdata), .q(cfg_en));
  gpio_wm_reg #(.HW(HW), .BASE(OFS_MASK)) u_mask (
    .clk(clk), .rst_n(rst_n), .wen(reg_wen), .addr(reg_addr), .wdata(reg_wdata), .q(cfg_mask));
  gpio_wm_reg #(.HW(HW), .BASE(OFS_TYPE)) u_type (
    .clk(clk), .rst_n(rst_n), .wen(reg_wen), .addr(reg_addr), .wdata(reg_wdata), .q(cfg_type));
  gpio_wm_reg #(.HW(HW), .BASE(OFS_POL)) u_pol (
    .clk(clk), .rst_n(rst_n), .wen(reg_wen), .addr(reg_addr), .wdata(reg_wdata), .q(cfg_pol));
  gpio_wm_reg #(.HW(HW), .BASE(OFS_BOTH)) u_both (
    .clk(clk), .rst_n(rst_n), .wen(reg_wen), .addr(reg_addr), .wdata(reg_wdata), .q(cfg_both));

  // acknowledge is a one-cycle pulse; only enabled bits set to 1 clear
  for (genvar h = 0; h < 2; h++) begin : g_eoi
    localparam logic [ADDR_W-1:0] EOI_ADDR = OFS_EOI + ADDR_W'(h * HI_STEP);
    assign eoi_clr[h*HW +: HW] = (reg_wen && reg_addr == EOI_ADDR)
                               ? (reg_wdata[HW-1:0] & reg_wdata[NPINS-1:HW]) : '0;
  end

  gpio_pin_detect #(.NP(NPINS)) u_det (
    .clk(clk), .rst_n(rst_n), .pin(pin_lvl), .en(cfg_en), .etype(cfg_type),
    .pol(cfg_pol), .both(cfg_both), .eoi_clr(eoi_clr), .hit(hit), .pend(pend), .raw(raw));

  assign stat = raw & ~cfg_mask;
  assign irq  = |stat;

  always_comb begin
    rd_sel = '0;
    if (reg_addr[1:0] == 2'b00) begin
      unique case ({reg_addr[ADDR_W-1:3], 3'b000})
        OFS_EN:   rd_sel = cfg_en;
        OFS_MASK: rd_sel = cfg_mask;
        OFS_TYPE: rd_sel = cfg_type;
        OFS_POL:  rd_sel = cfg_pol;
        OFS_BOTH: rd_sel = cfg_both;
        OFS_STAT: rd_sel = stat;
        OFS_RAW:  rd_sel = raw;
        default:  rd_sel = '0;
      endcase
    end
    reg_rdata = {{HW{1'b0}}, (reg_addr[2] ? rd_sel[NPINS-1:HW] : rd_sel[HW-1:0])};
  end
endmodule

// File: rtl/gpio_irq_detect_chk.sv
module gpio_irq_detect_chk #(
  parameter int unsigned NP = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic [NP-1:0] pin_lvl,
  input logic          irq,
  input logic [NP-1:0] cfg_en,
  input logic [NP-1:0] cfg_mask,
  input logic [NP-1:0] cfg_type,
  input logic [NP-1:0] cfg_pol,
  input logic [NP-1:0] cfg_both,
  input logic [NP-1:0] eoi_clr,
  input logic [NP-1:0] hit,
  input logic [NP-1:0] pend,
  input logic [NP-1:0] raw
);
  // R3
  level_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((raw ^ ~(pin_lvl ^ cfg_pol)) & cfg_en & ~cfg_type & ~cfg_both) == '0);

  // R11
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (raw & ~cfg_en) == '0);

  // R6
  eoi_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend & $past(eoi_clr & ~hit)) == '0));

  // R8
  edge_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend & $past(hit)) == $past(hit)));

  // R10
  irq_or_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (|(raw & ~cfg_mask)));
endmodule

bind gpio_irq_detect gpio_irq_detect_chk #(.NP(NPINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .pin_lvl(pin_lvl), .irq(irq),
  .cfg_en(cfg_en), .cfg_mask(cfg_mask), .cfg_type(cfg_type), .cfg_pol(cfg_pol),
  .cfg_both(cfg_both), .eoi_clr(eoi_clr), .hit(hit), .pend(pend), .raw(raw));

// File: tb/test_gpio_irq_detect.sv
module test_gpio_irq_detect;
  import gpio_irq_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] b_pin = '0;
  logic        b_wen = 1'b0;
  logic [7:0]  b_addr = '0;
  logic [31:0] b_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // bench model state
  logic [31:0] m_en = '0, m_mask = '0, m_type = '0, m_pol = '0, m_both = '0;
  logic [31:0] m_prev = '0, m_pend = '0;

  always #5 clk = ~clk;

  gpio_irq_detect i_gpio_irq_detect (
    .clk(clk), .rst_n(rst_n), .pin_lvl(b_pin), .reg_wen(b_wen),
    .reg_addr(b_addr), .reg_wdata(b_wdata), .reg_rdata(reg_rdata), .irq(irq));

  function automatic logic [31:0] wm(input logic [31:0] old, input logic [31:0] wd, input logic hi);
    logic [31:0] r = old;
    if (hi) r[31:16] = (old[31:16] & ~wd[31:16]) | (wd[15:0] & wd[31:16]);
    else    r[15:0]  = (old[15:0]  & ~wd[31:16]) | (wd[15:0] & wd[31:16]);
    return r;
  endfunction

  function automatic logic [31:0] m_raw();
    logic [31:0] em = m_type | m_both;
    return m_en & ((em & m_pend) | (~em & ~(b_pin ^ m_pol)));
  endfunction

  function automatic logic [31:0] m_read(input logic [7:0] a);
    logic [31:0] s = '0;
    if (a[1:0] == 2'b00) begin
      case ({a[7:3], 3'b000})
        OFS_EN:   s = m_en;
        OFS_MASK: s = m_mask;
        OFS_TYPE: s = m_type;
        OFS_POL:  s = m_pol;
        OFS_BOTH: s = m_both;
        OFS_STAT: s = m_raw() & ~m_mask;
        OFS_RAW:  s = m_raw();
        default:  s = '0;
      endcase
    end
    return {16'h0, (a[2] ? s[31:16] : s[15:0])};
  endfunction

  // advance the model over the clock edge that just used the held inputs
  task automatic m_step();
    logic [31:0] em, ev, hitv, clr, a_base;
    logic hi;
    em   = m_type | m_both;
    ev   = (m_both & (b_pin ^ m_prev)) |
           (~m_both & m_pol & b_pin & ~m_prev) |
           (~m_both & ~m_pol & ~b_pin & m_prev);
    hitv = m_en & em & ev;
    clr  = '0;
    hi   = b_addr[2];
    a_base = {24'h0, b_addr[7:3], 3'b000};
    if (b_wen && b_addr[1:0] == 2'b00 && a_base[7:0] == OFS_EOI)
      clr = hi ? {b_wdata[15:0] & b_wdata[31:16], 16'h0} : {16'h0, b_wdata[15:0] & b_wdata[31:16]};
    m_pend = m_en & em & ((m_pend & ~clr) | hitv);
    m_prev = b_pin;
    if (b_wen && b_addr[1:0] == 2'b00) begin
      case (a_base[7:0])
        OFS_EN:   m_en   = wm(m_en,   b_wdata, hi);
        OFS_MASK: m_mask = wm(m_mask, b_wdata, hi);
        OFS_TYPE: m_type = wm(m_type, b_wdata, hi);
        OFS_POL:  m_pol  = wm(m_pol,  b_wdata, hi);
        OFS_BOTH: m_both = wm(m_both, b_wdata, hi);
        default: ;
      endcase
    end
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic cyc(input string tag, input logic wen, input logic [7:0] a,
                     input logic [31:0] wd, input logic [31:0] p);
    @(negedge clk);
    m_step();
    b_wen = wen; b_addr = a; b_wdata = wd; b_pin = p;
    #1;
    chk({tag, " rdata"}, reg_rdata, m_read(a));
    chk({tag, " irq"}, {31'h0, irq}, {31'h0, |(m_raw() & ~m_mask)});
  endtask

  task automatic wr(input string tag, input logic [7:0] a, input logic [31:0] wd);
    cyc(tag, 1'b1, a, wd, b_pin);
  endtask
  task automatic rd(input string tag, input logic [7:0] a);
    cyc(tag, 1'b0, a, 32'h0, b_pin);
  endtask
  task automatic setpin(input string tag, input logic [31:0] p);
    cyc(tag, 1'b0, b_addr, 32'h0, p);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : stim
    logic [7:0] bases [8];
    bases = '{OFS_EN, OFS_MASK, OFS_TYPE, OFS_POL, OFS_BOTH, OFS_STAT, OFS_RAW, OFS_EOI};
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int i = 0; i < 8; i++) begin
      rd("R1", bases[i]);
      chk("R1 lo literal", reg_rdata, 32'h0);
      rd("R1", bases[i] + HI_STEP);
    end

    // R2 write-mask convention
    wr("R2", OFS_EN, 32'h00FF_FFFF);
    rd("R2", OFS_EN);           chk("R2 lo literal", reg_rdata, 32'h0000_00FF);
    wr("R2", OFS_EN, 32'h0003_0001);
    rd("R2", OFS_EN);           chk("R2 masked bits literal", reg_rdata, 32'h0000_00FD);
    rd("R2", OFS_EN + HI_STEP); chk("R2 hi untouched", reg_rdata, 32'h0);
    wr("R2", OFS_EN, 32'hFFFF_FFFF);
    wr("R2", OFS_EN + HI_STEP, 32'hFFFF_FFFF);

    // R3 level mode: pins low, polarity 0 -> all active
    rd("R3", OFS_RAW);          chk("R3 active low literal", reg_rdata, 32'h0000_FFFF);
    setpin("R3", 32'hFFFF_FFFF);
    rd("R3", OFS_RAW);          chk("R3 inactive literal", reg_rdata, 32'h0);
    wr("R3", OFS_POL, 32'h0001_0001);
    rd("R3", OFS_RAW);          chk("R3 active high literal", reg_rdata, 32'h0000_0001);

    // R4 edge mode: pin0 rising, others falling
    wr("R4", OFS_TYPE, 32'hFFFF_FFFF);
    wr("R4", OFS_TYPE + HI_STEP, 32'hFFFF_FFFF);
    rd("R4", OFS_RAW);          chk("R4 no edge yet", reg_rdata, 32'h0);
    setpin("R4", 32'h0000_0000);
    rd("R4", OFS_RAW);          chk("R4 falling latched", reg_rdata, 32'h0000_FFFE);
    setpin("R4", 32'h0000_0001);
    setpin("R4", 32'h0000_0000);
    rd("R4", OFS_RAW);          chk("R4 rising latched and sticky", reg_rdata, 32'h0000_FFFF);
    wr("R6", OFS_EOI, 32'hFFFF_FFFF);
    wr("R6", OFS_EOI + HI_STEP, 32'hFFFF_FFFF);
    rd("R6", OFS_RAW);          chk("R6 cleared", reg_rdata, 32'h0);
    rd("R6", OFS_EOI);          chk("R6 eoi reads zero", reg_rdata, 32'h0);

    // R5 both edges on pin1 (polarity 0 would ignore a rise)
    wr("R5", OFS_BOTH, 32'h0002_0002);
    setpin("R5", 32'h0000_0002);
    rd("R5", OFS_RAW);          chk("R5 rise on both-edge", reg_rdata, 32'h0000_0002);
    wr("R6", OFS_EOI, 32'h0000_0002);
    rd("R6", OFS_RAW);          chk("R6 no write-enable keeps", reg_rdata, 32'h0000_0002);
    wr("R6", OFS_EOI, 32'h0002_0002);
    rd("R6", OFS_RAW);          chk("R6 clear pin1", reg_rdata, 32'h0);
    setpin("R5", 32'h0000_0000);
    rd("R5", OFS_RAW);          chk("R5 fall on both-edge", reg_rdata, 32'h0000_0002);
    wr("R6", OFS_EOI, 32'h0002_0002);

    // R8 edge and acknowledge on the same clock edge
    cyc("R8", 1'b1, OFS_EOI, 32'h0002_0002, 32'h0000_0002);
    rd("R8", OFS_RAW);          chk("R8 edge wins", reg_rdata, 32'h0000_0002);

    // R7 level pin3 ignores acknowledge
    wr("R7", OFS_TYPE, 32'h0008_0000);
    rd("R7", OFS_RAW);          chk("R7 level active", reg_rdata, 32'h0000_000A);
    wr("R7", OFS_EOI, 32'hFFFF_FFFF);
    rd("R7", OFS_RAW);          chk("R7 level after eoi", reg_rdata, 32'h0000_0008);

    // R9 / R10 masking and combined output
    wr("R9", OFS_MASK, 32'hFFFF_FFFF);
    rd("R9", OFS_STAT);         chk("R9 all masked", reg_rdata, 32'h0);
    rd("R9", OFS_RAW);          chk("R9 raw unchanged", reg_rdata, 32'h0000_0008);
    chk("R10 irq low when masked", {31'h0, irq}, 32'h0);
    wr("R10", OFS_MASK, 32'h0008_0000);
    rd("R10", OFS_STAT);        chk("R10 stat pin3", reg_rdata, 32'h0000_0008);
    chk("R10 irq high", {31'h0, irq}, 32'h1);

    // R11 disable clears and ignores transitions
    setpin("R11", 32'h0000_0002);
    wr("R11", OFS_EN, 32'h0002_0000);
    rd("R11", OFS_RAW);         chk("R11 disabled raw", reg_rdata, 32'h0000_0008);
    setpin("R11", 32'h0000_0000);
    setpin("R11", 32'h0000_0002);
    wr("R11", OFS_EN, 32'h0002_0002);
    rd("R11", OFS_RAW);         chk("R11 nothing remembered", reg_rdata, 32'h0000_0008);

    // R12 read-only status addresses
    wr("R12", OFS_RAW, 32'hFFFF_0000);
    wr("R12", OFS_STAT + HI_STEP, 32'hFFFF_FFFF);
    rd("R12", OFS_RAW);         chk("R12 raw write ignored", reg_rdata, 32'h0000_0008);

    // constrained random traffic, checked every cycle against the model
    for (int n = 0; n < 4000; n++) begin
      logic [31:0] pv;
      logic [7:0]  a;
      a  = bases[$urandom_range(0, 7)] + (($urandom_range(0, 1) == 1) ? HI_STEP : 8'h0);
      pv = b_pin ^ ($urandom() & $urandom() & $urandom());
      if ($urandom_range(0, 9) < 3)
        cyc("R2-R12 random", 1'b1, a, $urandom(), pv);
      else
        cyc("R3 R4 R5 R9 random", 1'b0, a, 32'h0, pv);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule